// File: doc/BRIEF.md
# DMA Controller Register File and Interrupt Block

This block is the software-facing register file of a multi-channel DMA controller. It is built for either two or eight channels, chosen by a parameter. A word-addressed bus with a 12-bit byte address reaches four kinds of location: global status and control words, five 32-bit words per channel, eight read-only identification bytes, and everything else, which reads as zero.

The block keeps the raw terminal-count and error interrupt bits and drives three level interrupts from them. The per-channel masks are not registers of their own. Each channel takes them from two bits of its configuration word.

Towards the channel engine, every channel register appears on a flattened output bus, along with the global enable and the bitmap of enabled channels. The engine raises interrupt bits and retires channels through one-cycle strobes. The block pulses a kick strobe after any write that may start new work.

Reads are combinational: `bus_rdata` shows the addressed word while `bus_en` is high and is zero otherwise. A write takes effect at the clock edge where `bus_en` and `bus_we` are both high. No data stream flows through this block, so it has no valid/ready interface. Its ports are plain control and status pins.

Top module: `dmac_regfile`

## Requirements
- R1: After reset, every channel word, the raw interrupt bits, the global configuration and the sync word read as zero. All three interrupt outputs and `eng_kick` are low.
- R2: A channel word sits at byte address 0x100 + 32*ch + 4*k, where k = 0 is source, 1 is destination, 2 is link pointer, 3 is control and 4 is configuration. Each of these words is fully writable, reads back what was written and appears on the matching `ch_*_flat` slice. Slots k = 5..7 read as zero and ignore writes.
- R3: Any access whose channel field, byte-address bits [7:5], is at or above NUM_CH reads as zero and changes no state.
- R4: Global word 0 (byte address 0x000) reads masked TC OR masked error. Word 1 reads masked TC. Word 3 reads masked error. Word 5 reads raw TC. Word 6 reads raw error. Channel n sits at bit n in all of these.
- R5: Writing global word 2 clears each raw TC bit whose write-data bit is one. Writing word 4 does the same for raw error bits. A set strobe from the engine in the same cycle wins over the clear.
- R6: The TC mask bit of channel n is bit 15 of its configuration word, and its error mask bit is bit 14.
- R7: Global word 7 reads the bitmap of configuration bit 0 over all channels. An `eng_ch_done` strobe clears that bit, unless software writes the same configuration word in the same cycle, in which case the software write wins.
- R8: Global word 12 is a 32-bit configuration word whose bit 0 drives `ctl_enable`. Global word 13 is a 32-bit read/write sync word.
- R9: Byte addresses 0xFE0..0xFFC return one identification byte per word, in bits [7:0]. The sequence is 0x80 (for 8 channels) or 0x81 (for 2 channels), then 0x10, 0x04, 0x0A, 0x0D, 0xF0, 0x05, 0xB1.
- R10: Global words 8..11 and 14..63, and byte addresses 0x200..0xFDF, read as zero and ignore writes.
- R11: `irq_tc` is high when any masked TC bit is set, `irq_err` is high when any masked error bit is set, and `irq_any` is their OR. All three are registered, so each follows the state with a lag of exactly one cycle.
- R12: `eng_kick` is high for exactly the one cycle after a write to a valid channel's configuration word or to global word 12. No other write raises it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_en | input | 1 | Access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte address (bits [1:0] ignored) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (combinational) |
| eng_tc_set | input | NUM_CH | Engine sets raw TC bits |
| eng_err_set | input | NUM_CH | Engine sets raw error bits |
| eng_ch_done | input | NUM_CH | Engine clears channel enable bits |
| ctl_enable | output | 1 | Global enable |
| ch_enabled | output | NUM_CH | Channel enable bitmap |
| ch_src_flat | output | 32*NUM_CH | Source words |
| ch_dst_flat | output | 32*NUM_CH | Destination words |
| ch_lli_flat | output | 32*NUM_CH | Link pointer words |
| ch_ctl_flat | output | 32*NUM_CH | Control words |
| ch_cfg_flat | output | 32*NUM_CH | Configuration words |
| eng_kick | output | 1 | Start-check pulse to the engine |
| irq_tc | output | 1 | Masked terminal-count interrupt |
| irq_err | output | 1 | Masked error interrupt |
| irq_any | output | 1 | OR of both interrupts |

## Verification
A wrong raw bit or a wrong mask bit shows up at once on the combinational status reads. The interrupt pins show the same fault one cycle later, so the bench compares the two paths against each other and against the cycle of the stimulus that caused them. A decode slip, such as an aliased channel, a write to an undefined slot that lands somewhere, or a stray kick, becomes visible only when the disturbed location is read. For that reason every ignored write is followed by a read-back of the locations it could have reached before the next stimulus is applied.

// File: rtl/dmac_pkg.sv
package dmac_pkg;
  localparam int WORD_W  = 32;
  localparam int BUS_AW  = 12;
  localparam int CH_IDXW = 3;
  localparam int GIDX_W  = 6;

  localparam logic [2:0] CR_SRC = 3'd0;
  localparam logic [2:0] CR_DST = 3'd1;
  localparam logic [2:0] CR_LLI = 3'd2;
  localparam logic [2:0] CR_CTL = 3'd3;
  localparam logic [2:0] CR_CFG = 3'd4;

  localparam logic [GIDX_W-1:0] G_STAT  = 6'd0;
  localparam logic [GIDX_W-1:0] G_TCST  = 6'd1;
  localparam logic [GIDX_W-1:0] G_TCCLR = 6'd2;
  localparam logic [GIDX_W-1:0] G_ERST  = 6'd3;
  localparam logic [GIDX_W-1:0] G_ERCLR = 6'd4;
  localparam logic [GIDX_W-1:0] G_RAWTC = 6'd5;
  localparam logic [GIDX_W-1:0] G_RAWER = 6'd6;
  localparam logic [GIDX_W-1:0] G_ENMAP = 6'd7;
  localparam logic [GIDX_W-1:0] G_GCFG  = 6'd12;
  localparam logic [GIDX_W-1:0] G_SYNC  = 6'd13;

  localparam int CFG_EN_BIT  = 0;
  localparam int CFG_ERM_BIT = 14;
  localparam int CFG_TCM_BIT = 15;

  typedef struct packed {
    logic                hit_ch;
    logic                hit_glb;
    logic                hit_id;
    logic [CH_IDXW-1:0]  ch;
    logic [2:0]          creg;
    logic [GIDX_W-1:0]   gidx;
    logic [2:0]          idb;
  } dec_t;

  function automatic dec_t decode_addr(input logic [BUS_AW-1:0] a);
    dec_t d;
    d.hit_ch  = (a[11:8] == 4'h1);
    d.hit_glb = (a[11:8] == 4'h0);
    d.hit_id  = (a[11:5] == 7'h7F);
    d.ch      = a[7:5];
    d.creg    = a[4:2];
    d.gidx    = a[7:2];
    d.idb     = a[4:2];
    return d;
  endfunction

  function automatic logic [7:0] id_byte(input int nch, input logic [2:0] idx);
    case (idx)
      3'd0:    return (nch == 8) ? 8'h80 : 8'h81;
      3'd1:    return 8'h10;
      3'd2:    return 8'h04;
      3'd3:    return 8'h0A;
      3'd4:    return 8'h0D;
      3'd5:    return 8'hF0;
      3'd6:    return 8'h05;
      default: return 8'hB1;
    endcase
  endfunction
endpackage

// File: rtl/dmac_chan_bank.sv
module dmac_chan_bank
  import dmac_pkg::*;
#(
  parameter int NUM_CH = 8,
  localparam int CW = NUM_CH * WORD_W
)(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [CH_IDXW-1:0] wr_ch,
  input  logic [2:0]         wr_reg,
  input  logic [WORD_W-1:0]  wr_data,
  input  logic [NUM_CH-1:0]  done,
  output logic [CW-1:0]      src_flat,
  output logic [CW-1:0]      dst_flat,
  output logic [CW-1:0]      lli_flat,
  output logic [CW-1:0]      ctl_flat,
  output logic [CW-1:0]      cfg_flat
);
  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic              sel;
    logic [WORD_W-1:0] src_q, dst_q, lli_q, ctl_q, cfg_q;

    assign sel = wr_en && (wr_ch == CH_IDXW'(c));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        src_q <= '0;
        dst_q <= '0;
        lli_q <= '0;
        ctl_q <= '0;
        cfg_q <= '0;
      end else begin
        if (sel && wr_reg == CR_SRC) src_q <= wr_data;
        if (sel && wr_reg == CR_DST) dst_q <= wr_data;
        if (sel && wr_reg == CR_LLI) lli_q <= wr_data;
        if (sel && wr_reg == CR_CTL) ctl_q <= wr_data;
        if (sel && wr_reg == CR_CFG) cfg_q <= wr_data;
        else if (done[c])            cfg_q[CFG_EN_BIT] <= 1'b0;
      end
    end

    assign src_flat[c*WORD_W +: WORD_W] = src_q;
    assign dst_flat[c*WORD_W +: WORD_W] = dst_q;
    assign lli_flat[c*WORD_W +: WORD_W] = lli_q;
    assign ctl_flat[c*WORD_W +: WORD_W] = ctl_q;
    assign cfg_flat[c*WORD_W +: WORD_W] = cfg_q;
  end
endmodule

// File: rtl/dmac_irq_ctrl.sv
module dmac_irq_ctrl #(
  parameter int NUM_CH = 8
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] tc_set,
  input  logic [NUM_CH-1:0] err_set,
  input  logic              tc_clr_we,
  input  logic              err_clr_we,
  input  logic [NUM_CH-1:0] clr_bits,
  input  logic [NUM_CH-1:0] tc_mask,
  input  logic [NUM_CH-1:0] err_mask,
  output logic [NUM_CH-1:0] raw_tc,
  output logic [NUM_CH-1:0] raw_err,
  output logic              irq_tc,
  output logic              irq_err,
  output logic              irq_any
);
  logic [NUM_CH-1:0] tc_kill, err_kill;
  logic              tc_lvl, err_lvl;

  assign tc_kill = tc_clr_we  ? clr_bits : '0;
  assign err_kill = err_clr_we ? clr_bits : '0;
  assign tc_lvl  = |(raw_tc & tc_mask);
  assign err_lvl = |(raw_err & err_mask);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      raw_tc  <= '0;
      raw_err <= '0;
      irq_tc  <= 1'b0;
      irq_err <= 1'b0;
      irq_any <= 1'b0;
    end else begin
      raw_tc  <= (raw_tc & ~tc_kill) | tc_set;
      raw_err <= (raw_err & ~err_kill) | err_set;
      irq_tc  <= tc_lvl;
      irq_err <= err_lvl;
      irq_any <= tc_lvl | err_lvl;
    end
  end
endmodule

// File: rtl/dmac_rd_mux.sv
module dmac_rd_mux
  import dmac_pkg::*;
#(
  parameter int NUM_CH = 8,
  localparam int CW = NUM_CH * WORD_W
)(
  input  logic              bus_en,
  input  dec_t              dec,
  input  logic              ch_ok,
  input  logic [CW-1:0]     src_flat,
  input  logic [CW-1:0]     dst_flat,
  input  logic [CW-1:0]     lli_flat,
  input  logic [CW-1:0]     ctl_flat,
  input  logic [CW-1:0]     cfg_flat,
  input  logic [NUM_CH-1:0] raw_tc,
  input  logic [NUM_CH-1:0] raw_err,
  input  logic [NUM_CH-1:0] tc_mask,
  input  logic [NUM_CH-1:0] err_mask,
  input  logic [NUM_CH-1:0] en_map,
  input  logic [WORD_W-1:0] gcfg,
  input  logic [WORD_W-1:0] sync_w,
  output logic [WORD_W-1:0] rdata
);
  logic [WORD_W-1:0] word;
  logic [NUM_CH-1:0] m_tc, m_err;

  assign m_tc  = raw_tc & tc_mask;
  assign m_err = raw_err & err_mask;

  always_comb begin
    word = '0;
    if (dec.hit_id) begin
      word = {{(WORD_W-8){1'b0}}, id_byte(NUM_CH, dec.idb)};
    end else if (dec.hit_ch && ch_ok) begin
      for (int i = 0; i < NUM_CH; i++) begin
        if (dec.ch == CH_IDXW'(i)) begin
          case (dec.creg)
            CR_SRC:  word = src_flat[i*WORD_W +: WORD_W];
            CR_DST:  word = dst_flat[i*WORD_W +: WORD_W];
            CR_LLI:  word = lli_flat[i*WORD_W +: WORD_W];
            CR_CTL:  word = ctl_flat[i*WORD_W +: WORD_W];
            CR_CFG:  word = cfg_flat[i*WORD_W +: WORD_W];
            default: word = '0;
          endcase
        end
      end
    end else if (dec.hit_glb) begin
      case (dec.gidx)
        G_STAT:  word = WORD_W'(m_tc | m_err);
        G_TCST:  word = WORD_W'(m_tc);
        G_ERST:  word = WORD_W'(m_err);
        G_RAWTC: word = WORD_W'(raw_tc);
        G_RAWER: word = WORD_W'(raw_err);
        G_ENMAP: word = WORD_W'(en_map);
        G_GCFG:  word = gcfg;
        G_SYNC:  word = sync_w;
        default: word = '0;
      endcase
    end
  end

  assign rdata = bus_en ? word : '0;
endmodule

// File: rtl/dmac_regfile.sv
module dmac_regfile
  import dmac_pkg::*;
#(
  parameter int NUM_CH = 8,
  localparam int CW = NUM_CH * WORD_W
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [11:0]       bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [NUM_CH-1:0] eng_tc_set,
  input  logic [NUM_CH-1:0] eng_err_set,
  input  logic [NUM_CH-1:0] eng_ch_done,
  output logic              ctl_enable,
  output logic [NUM_CH-1:0] ch_enabled,
  output logic [CW-1:0]     ch_src_flat,
  output logic [CW-1:0]     ch_dst_flat,
  output logic [CW-1:0]     ch_lli_flat,
  output logic [CW-1:0]     ch_ctl_flat,
  output logic [CW-1:0]     ch_cfg_flat,
  output logic              eng_kick,
  output logic              irq_tc,
  output logic              irq_err,
  output logic              irq_any
);
  dec_t              dec;
  logic              ch_ok, wr_any, ch_wr, glb_wr;
  logic              wr_gcfg, wr_sync, wr_tcclr, wr_erclr;
  logic [WORD_W-1:0] gcfg_q, sync_q;
  logic [NUM_CH-1:0] tc_mask, err_mask, raw_tc, raw_err;

  assign dec      = decode_addr(bus_addr);
  assign ch_ok    = int'(dec.ch) < NUM_CH;
  assign wr_any   = bus_en && bus_we;
  assign ch_wr    = wr_any && dec.hit_ch && ch_ok && (dec.creg <= CR_CFG);
  assign glb_wr   = wr_any && dec.hit_glb;
  assign wr_gcfg  = glb_wr && (dec.gidx == G_GCFG);
  assign wr_sync  = glb_wr && (dec.gidx == G_SYNC);
  assign wr_tcclr = glb_wr && (dec.gidx == G_TCCLR);
  assign wr_erclr = glb_wr && (dec.gidx == G_ERCLR);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gcfg_q   <= '0;
      sync_q   <= '0;
      eng_kick <= 1'b0;
    end else begin
      if (wr_gcfg) gcfg_q <= bus_wdata;
      if (wr_sync) sync_q <= bus_wdata;
      eng_kick <= wr_gcfg || (ch_wr && dec.creg == CR_CFG);
    end
  end

  assign ctl_enable = gcfg_q[0];

  dmac_chan_bank #(.NUM_CH(NUM_CH)) bank_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (ch_wr),
    .wr_ch    (dec.ch),
    .wr_reg   (dec.creg),
    .wr_data  (bus_wdata),
    .done     (eng_ch_done),
    .src_flat (ch_src_flat),
    .dst_flat (ch_dst_flat),
    .lli_flat (ch_lli_flat),
    .ctl_flat (ch_ctl_flat),
    .cfg_flat (ch_cfg_flat)
  );

  for (genvar i = 0; i < NUM_CH; i++) begin : g_mask
    assign tc_mask[i]    = ch_cfg_flat[i*WORD_W + CFG_TCM_BIT];
    assign err_mask[i]   = ch_cfg_flat[i*WORD_W + CFG_ERM_BIT];
    assign ch_enabled[i] = ch_cfg_flat[i*WORD_W + CFG_EN_BIT];
  end

  dmac_irq_ctrl #(.NUM_CH(NUM_CH)) irq_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .tc_set     (eng_tc_set),
    .err_set    (eng_err_set),
    .tc_clr_we  (wr_tcclr),
    .err_clr_we (wr_erclr),
    .clr_bits   (bus_wdata[NUM_CH-1:0]),
    .tc_mask    (tc_mask),
    .err_mask   (err_mask),
    .raw_tc     (raw_tc),
    .raw_err    (raw_err),
    .irq_tc     (irq_tc),
    .irq_err    (irq_err),
    .irq_any    (irq_any)
  );

  dmac_rd_mux #(.NUM_CH(NUM_CH)) rd_i (
    .bus_en   (bus_en),
    .dec      (dec),
    .ch_ok    (ch_ok),
    .src_flat (ch_src_flat),
    .dst_flat (ch_dst_flat),
    .lli_flat (ch_lli_flat),
    .ctl_flat (ch_ctl_flat),
    .cfg_flat (ch_cfg_flat),
    .raw_tc   (raw_tc),
    .raw_err  (raw_err),
    .tc_mask  (tc_mask),
    .err_mask (err_mask),
    .en_map   (ch_enabled),
    .gcfg     (gcfg_q),
    .sync_w   (sync_q),
    .rdata    (bus_rdata)
  );
endmodule

// File: rtl/dmac_regfile_chk.sv
module dmac_regfile_chk #(
  parameter int NUM_CH = 8
)(
  input logic              clk,
  input logic              rst_n,
  input logic              bus_en,
  input logic              bus_we,
  input logic [11:0]       bus_addr,
  input logic [31:0]       bus_wdata,
  input logic [NUM_CH-1:0] eng_tc_set,
  input logic [NUM_CH-1:0] raw_tc,
  input logic [NUM_CH-1:0] tc_mask,
  input logic              irq_tc,
  input logic              irq_err,
  input logic              irq_any,
  input logic              eng_kick,
  input logic              ctl_enable
);
  logic gcfg_w, tcclr_w, chcfg_w;
  assign gcfg_w  = bus_en && bus_we && (bus_addr[11:2] == 10'd12);
  assign tcclr_w = bus_en && bus_we && (bus_addr[11:2] == 10'd2);
  assign chcfg_w = bus_en && bus_we && (bus_addr[11:8] == 4'h1) &&
                   (bus_addr[4:2] == 3'd4) && (int'(bus_addr[7:5]) < NUM_CH);

  assert_irq_any_R11: assert property (@(posedge clk) disable iff (!rst_n)
    irq_any == (irq_tc || irq_err));

  assert_irq_lag_R11: assert property (@(posedge clk) disable iff (!rst_n)
    irq_tc == $past(|(raw_tc & tc_mask)));

  assert_set_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (|eng_tc_set) |=> ((raw_tc & $past(eng_tc_set)) == $past(eng_tc_set)));

  assert_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (tcclr_w && eng_tc_set == '0) |=> ((raw_tc & $past(bus_wdata[NUM_CH-1:0])) == '0));

  assert_kick_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (gcfg_w || chcfg_w) |=> eng_kick);

  assert_enable_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !gcfg_w |=> $stable(ctl_enable));

  assert_enable_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
    gcfg_w |=> (ctl_enable == $past(bus_wdata[0])));
endmodule

bind dmac_regfile dmac_regfile_chk #(.NUM_CH(NUM_CH)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_en     (bus_en),
  .bus_we     (bus_we),
  .bus_addr   (bus_addr),
  .bus_wdata  (bus_wdata),
  .eng_tc_set (eng_tc_set),
  .raw_tc     (raw_tc),
  .tc_mask    (tc_mask),
  .irq_tc     (irq_tc),
  .irq_err    (irq_err),
  .irq_any    (irq_any),
  .eng_kick   (eng_kick),
  .ctl_enable (ctl_enable)
);

// File: tb/dmac_regfile_tb_top.sv
module dmac_regfile_tb_top;
  localparam int NCH = 2;
  localparam int CW  = NCH * 32;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           bus_en = 1'b0, bus_we = 1'b0;
  logic [11:0]    bus_addr = '0;
  logic [31:0]    bus_wdata = '0;
  logic [31:0]    bus_rdata;
  logic [NCH-1:0] eng_tc_set = '0, eng_err_set = '0, eng_ch_done = '0;
  logic           ctl_enable, eng_kick, irq_tc, irq_err, irq_any;
  logic [NCH-1:0] ch_enabled;
  logic [CW-1:0]  ch_src_flat, ch_dst_flat, ch_lli_flat, ch_ctl_flat, ch_cfg_flat;

  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;

  dmac_regfile #(.NUM_CH(NCH)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .eng_tc_set(eng_tc_set), .eng_err_set(eng_err_set), .eng_ch_done(eng_ch_done),
    .ctl_enable(ctl_enable), .ch_enabled(ch_enabled),
    .ch_src_flat(ch_src_flat), .ch_dst_flat(ch_dst_flat), .ch_lli_flat(ch_lli_flat),
    .ch_ctl_flat(ch_ctl_flat), .ch_cfg_flat(ch_cfg_flat),
    .eng_kick(eng_kick), .irq_tc(irq_tc), .irq_err(irq_err), .irq_any(irq_any)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [11:0] cha(input int c, input int r);
    return 12'h100 | 12'(c << 5) | 12'(r << 2);
  endfunction

  function automatic logic [11:0] ga(input int i);
    return 12'(i << 2);
  endfunction

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_en = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    bus_en = 1'b0;
  endtask

  task automatic pulse(input logic [NCH-1:0] t, input logic [NCH-1:0] e,
                       input logic [NCH-1:0] dn);
    @(negedge clk);
    eng_tc_set = t; eng_err_set = e; eng_ch_done = dn;
    @(negedge clk);
    eng_tc_set = '0; eng_err_set = '0; eng_ch_done = '0;
  endtask

  function automatic logic [31:0] pat(input int c, input int r);
    return (32'hA5C3_0F00 ^ 32'(c * 32'h0101_0110) ^ 32'(r * 32'h1230_0450)) & 32'hFFFF_3FFE;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog R1 act=timeout exp=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    for (int c = 0; c < NCH; c++)
      for (int r = 0; r < 5; r++) begin
        rd(cha(c, r), d); chk("R1 chan word", d, 32'h0);
      end
    for (int i = 0; i < 14; i++) begin
      rd(ga(i), d); chk("R1 global word", d, 32'h0);
    end
    chk("R1 irq", {29'b0, irq_tc, irq_err, irq_any}, 32'h0);
    chk("R1 kick", {31'b0, eng_kick}, 32'h0);

    // R2: channel words write/readback and view buses
    for (int c = 0; c < NCH; c++)
      for (int r = 0; r < 8; r++) wr(cha(c, r), pat(c, r));
    for (int c = 0; c < NCH; c++) begin
      for (int r = 0; r < 8; r++) begin
        rd(cha(c, r), d);
        chk("R2 readback", d, (r < 5) ? pat(c, r) : 32'h0);
      end
      chk("R2 src view", ch_src_flat[c*32 +: 32], pat(c, 0));
      chk("R2 dst view", ch_dst_flat[c*32 +: 32], pat(c, 1));
      chk("R2 lli view", ch_lli_flat[c*32 +: 32], pat(c, 2));
      chk("R2 ctl view", ch_ctl_flat[c*32 +: 32], pat(c, 3));
      chk("R2 cfg view", ch_cfg_flat[c*32 +: 32], pat(c, 4));
    end

    // R3: channels beyond NUM_CH
    for (int c = NCH; c < 8; c++)
      for (int r = 0; r < 8; r++) begin
        wr(cha(c, r), 32'hFFFF_FFFF);
        rd(cha(c, r), d); chk("R3 high channel read", d, 32'h0);
      end
    for (int c = 0; c < NCH; c++)
      for (int r = 0; r < 5; r++) begin
        rd(cha(c, r), d); chk("R3 low channel intact", d, pat(c, r));
      end
    for (int c = 0; c < NCH; c++) wr(cha(c, 4), 32'h0);

    // R4 R6 R11 R5: mask and raw sweep
    for (int tm = 0; tm < 4; tm++)
      for (int em = 0; em < 4; em++) begin
        for (int c = 0; c < NCH; c++)
          wr(cha(c, 4), (32'((tm >> c) & 1) << 15) | (32'((em >> c) & 1) << 14));
        for (int rt = 0; rt < 4; rt++)
          for (int re = 0; re < 4; re++) begin
            logic [31:0] mt, me;
            mt = 32'(rt & tm);
            me = 32'(re & em);
            pulse(2'(rt), 2'(re), 2'b00);
            chk("R11 irq lags one cycle", {31'b0, irq_any}, 32'h0);
            @(negedge clk);
            chk("R11 irq_tc", {31'b0, irq_tc}, {31'b0, mt != 0});
            chk("R11 irq_err", {31'b0, irq_err}, {31'b0, me != 0});
            chk("R11 irq_any", {31'b0, irq_any}, {31'b0, (mt | me) != 0});
            rd(ga(0), d); chk("R4 combined status", d, mt | me);
            rd(ga(1), d); chk("R6 masked tc", d, mt);
            rd(ga(3), d); chk("R6 masked err", d, me);
            rd(ga(5), d); chk("R4 raw tc", d, 32'(rt));
            rd(ga(6), d); chk("R4 raw err", d, 32'(re));
            wr(ga(2), 32'h1);
            rd(ga(5), d); chk("R5 tc clear bit0", d, 32'(rt & 2));
            wr(ga(2), 32'hFFFF_FFFF);
            wr(ga(4), 32'hFFFF_FFFF);
            rd(ga(6), d); chk("R5 err clear", d, 32'h0);
            @(negedge clk);
          end
      end

    // R5: set beats clear in the same cycle
    pulse(2'b11, 2'b00, 2'b00);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b1; bus_addr = ga(2); bus_wdata = 32'h3;
    eng_tc_set = 2'b01;
    @(negedge clk);
    bus_en = 1'b0; bus_we = 1'b0; eng_tc_set = '0;
    rd(ga(5), d); chk("R5 set wins over clear", d, 32'h1);
    wr(ga(2), 32'h3);

    // R7: enable bitmap and retire strobe
    wr(cha(0, 4), 32'h1);
    wr(cha(1, 4), 32'h1);
    rd(ga(7), d); chk("R7 bitmap both", d, 32'h3);
    chk("R7 ch_enabled", 32'(ch_enabled), 32'h3);
    pulse(2'b00, 2'b00, 2'b01);
    rd(ga(7), d); chk("R7 done clears ch0", d, 32'h2);
    rd(cha(0, 4), d); chk("R7 cfg ch0 after done", d, 32'h0);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b1; bus_addr = cha(1, 4); bus_wdata = 32'h1;
    eng_ch_done = 2'b10;
    @(negedge clk);
    bus_en = 1'b0; bus_we = 1'b0; eng_ch_done = '0;
    rd(ga(7), d); chk("R7 write wins over done", d, 32'h2);
    wr(cha(1, 4), 32'h0);

    // R8: global configuration and sync
    wr(ga(12), 32'hDEAD_BEEF);
    rd(ga(12), d); chk("R8 gcfg readback", d, 32'hDEAD_BEEF);
    chk("R8 enable high", {31'b0, ctl_enable}, 32'h1);
    wr(ga(12), 32'h0000_0002);
    chk("R8 enable low", {31'b0, ctl_enable}, 32'h0);
    wr(ga(13), 32'h1234_5678);
    rd(ga(13), d); chk("R8 sync readback", d, 32'h1234_5678);

    // R9: identification bytes
    for (int i = 0; i < 8; i++) begin
      logic [7:0] idv [8];
      idv = '{8'h81, 8'h10, 8'h04, 8'h0A, 8'h0D, 8'hF0, 8'h05, 8'hB1};
      rd(12'hFE0 + 12'(i * 4), d); chk("R9 id byte", d, {24'b0, idv[i]});
    end

    // R10: undefined offsets
    for (int i = 8; i < 64; i++) begin
      if (i == 12 || i == 13) continue;
      wr(ga(i), 32'hFFFF_FFFF);
      rd(ga(i), d); chk("R10 undefined global", d, 32'h0);
    end
    for (int a = 12'h200; a < 12'hFE0; a += 12'h0F4) begin
      wr(12'(a), 32'hFFFF_FFFF);
      rd(12'(a), d); chk("R10 undefined block", d, 32'h0);
    end
    rd(ga(12), d); chk("R10 gcfg intact", d, 32'h2);
    rd(ga(13), d); chk("R10 sync intact", d, 32'h1234_5678);
    rd(ga(5), d);  chk("R10 raw tc intact", d, 32'h0);
    rd(cha(1, 0), d); chk("R10 chan intact", d, pat(1, 0));

    // R12: kick pulse
    wr(cha(1, 4), 32'h0);
    chk("R12 kick after cfg write", {31'b0, eng_kick}, 32'h1);
    @(negedge clk);
    chk("R12 kick one cycle", {31'b0, eng_kick}, 32'h0);
    wr(ga(12), 32'h1);
    chk("R12 kick after gcfg", {31'b0, eng_kick}, 32'h1);
    wr(cha(0, 0), 32'h55);
    chk("R12 no kick on src write", {31'b0, eng_kick}, 32'h0);
    wr(cha(5, 4), 32'h1);
    chk("R12 no kick on bad channel", {31'b0, eng_kick}, 32'h0);
    wr(ga(13), 32'h1);
    chk("R12 no kick on sync", {31'b0, eng_kick}, 32'h0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule